// File: doc/BRIEF.md
# Iterative vector-to-polar converter

This block takes a two-dimensional vector whose components are signed 16-bit fractions (one sign bit, fifteen fraction bits) and returns its length and its direction. It works by shift-and-add rotations. Each clock cycle turns the vector by a fixed, shrinking angle towards the positive horizontal axis. It adds up the angles it has applied, and the total is the direction of the input. No multiplier is used.

A caller offers a vector on `x_in`/`y_in` with `start_valid`. The block accepts it on a rising edge where `start_ready` is high. The first cycle folds vectors that point into the left half plane by a quarter turn, so every quadrant is in range. The next fourteen cycles each perform one shift-and-add rotation. The rotation angles come from a small constant table indexed by the iteration number. When the work is finished, `done` pulses for one cycle. The outputs then hold the magnitude, still multiplied by the fixed gain of the rotations (about 1.6468), and the angle, until the next result replaces them. Only one vector is in flight at a time.

Top module: `cvec_polar`

## Requirements
- R1: During and after reset, with no start accepted yet, `start_ready` is 1, `done` is 0, and `mag_out` and `angle_out` are 0.
- R2: After an accepting edge (`start_valid` and `start_ready` both high), `start_ready` stays 0 until the cycle in which `done` is high. While `start_ready` is 0, `start_valid` and the input values are ignored: they produce no extra result and do not change the pending one.
- R3: `done` is high for exactly one cycle. That cycle follows the 14th rising edge after the accepting edge, so the work spans 15 cycles counting the accepting one.
- R4: `angle_out` is a 16-bit two's-complement angle in which 32768 stands for pi and 16384 for pi/2. It equals atan2(y, x) within ±16 LSB, compared modulo 2·pi, in all four quadrants and on the axes.
- R5: `mag_out` is an 18-bit two's-complement value with 15 fraction bits. It is never negative and equals 1.64676·sqrt(x²+y²) within ±40 LSB.
- R6: Inputs at negative full scale (-32768 in either or both components) produce correct results. The two guard bits absorb the growth from the quarter-turn fold and from the rotation gain.
- R7: The zero vector produces a magnitude of exactly 0.
- R8: A start offered in the cycle where `done` is high is accepted on that edge. The next `done` then follows exactly 15 cycles after the previous one.
- R9: `mag_out` and `angle_out` keep the last result unchanged while no new result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | A vector is offered on `x_in`/`y_in` |
| start_ready | output | 1 | High when a new vector can be accepted |
| x_in | input | 16 | Horizontal component, signed fraction with 15 fraction bits |
| y_in | input | 16 | Vertical component, signed fraction with 15 fraction bits |
| done | output | 1 | One-cycle pulse marking a fresh result |
| mag_out | output | 18 | Gain-scaled magnitude, 15 fraction bits |
| angle_out | output | 16 | Angle, 32768 = pi |

## Verification
The bench builds the block with its default parameters: 16-bit data, two guard bits and fourteen iterations. With these values the full-scale corners, where the folded and gain-grown magnitude reaches about 2.33, come within reach of the test. So does the residual angle error left after the last table entry used. Expected angles and magnitudes come from floating-point atan2 and square root with a tolerance. They are not a bit-true model of the datapath. Vectors on every axis and in every quadrant exercise both fold directions, and the inputs offered while the block is busy must leave the pending result and the result count untouched.

// File: rtl/cvec_pkg.sv
package cvec_pkg;

    localparam int ANG_W     = 16;
    localparam int ROM_DEPTH = 16;
    localparam int IDX_W     = $clog2(ROM_DEPTH);

    typedef logic signed [ANG_W-1:0] ang_t;

    // 2^(ANG_W-1) stands for pi, so a quarter turn is 2^(ANG_W-2).
    localparam ang_t ANG_QUARTER = ang_t'(1 << (ANG_W - 2));

    // Rotation angle of step k, atan(2^-k), rounded to the angle scale.
    function automatic ang_t step_angle(input logic [IDX_W-1:0] k);
        ang_t a;
        case (k)
            4'd0:    a = 16'sd8192;
            4'd1:    a = 16'sd4836;
            4'd2:    a = 16'sd2555;
            4'd3:    a = 16'sd1297;
            4'd4:    a = 16'sd651;
            4'd5:    a = 16'sd326;
            4'd6:    a = 16'sd163;
            4'd7:    a = 16'sd81;
            4'd8:    a = 16'sd41;
            4'd9:    a = 16'sd20;
            4'd10:   a = 16'sd10;
            4'd11:   a = 16'sd5;
            4'd12:   a = 16'sd3;
            4'd13:   a = 16'sd1;
            4'd14:   a = 16'sd1;
            default: a = 16'sd0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cvec_atan_rom.sv
module cvec_atan_rom
    import cvec_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output ang_t             angle
);

    always_comb begin
        angle = step_angle(idx);
    end

endmodule

// File: rtl/cvec_fold.sv
module cvec_fold
    import cvec_pkg::*;
#(
    parameter int W = 18
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o,
    output ang_t                z_o
);

    // Left half plane: turn by a quarter so that x becomes non-negative.
    always_comb begin
        if (x_i[W-1]) begin
            if (!y_i[W-1]) begin
                x_o = y_i;
                y_o = -x_i;
                z_o = ANG_QUARTER;
            end else begin
                x_o = -y_i;
                y_o = x_i;
                z_o = -ANG_QUARTER;
            end
        end else begin
            x_o = x_i;
            y_o = y_i;
            z_o = '0;
        end
    end

endmodule

// File: rtl/cvec_step.sv
module cvec_step
    import cvec_pkg::*;
#(
    parameter int W = 18
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  ang_t                z_i,
    input  logic [IDX_W-1:0]    shamt,
    input  ang_t                rot,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o,
    output ang_t                z_o
);

    logic signed [W-1:0] x_sh, y_sh;
    logic signed [W-1:0] x_add, x_sub, y_add, y_sub;
    ang_t                z_add, z_sub;
    logic                turn_up;

    // Both candidate updates exist in parallel; the sign of y picks one set.
    always_comb begin
        x_sh    = x_i >>> shamt;
        y_sh    = y_i >>> shamt;
        x_add   = x_i + y_sh;
        x_sub   = x_i - y_sh;
        y_add   = y_i + x_sh;
        y_sub   = y_i - x_sh;
        z_add   = z_i + rot;
        z_sub   = z_i - rot;
        turn_up = y_i[W-1];
        if (turn_up) begin
            x_o = x_sub;
            y_o = y_add;
            z_o = z_sub;
        end else begin
            x_o = x_add;
            y_o = y_sub;
            z_o = z_add;
        end
    end

endmodule

// File: rtl/cvec_polar.sv
module cvec_polar
    import cvec_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 2,
    parameter int ITERS   = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_valid,
    output logic                        start_ready,
    input  logic [DATA_W-1:0]           x_in,
    input  logic [DATA_W-1:0]           y_in,
    output logic                        done,
    output logic [DATA_W+GUARD_W-1:0]   mag_out,
    output logic [ANG_W-1:0]            angle_out
);

    localparam int W = DATA_W + GUARD_W;
    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(ITERS - 1);

    typedef struct packed {
        logic                busy;
        logic [IDX_W-1:0]    step;
        logic signed [W-1:0] x;
        logic signed [W-1:0] y;
        ang_t                z;
        logic                done;
        logic signed [W-1:0] mag;
        ang_t                ang;
    } state_t;

    state_t st_d, st_q;

    logic signed [W-1:0] x_ext, y_ext;
    logic signed [W-1:0] fold_x, fold_y, step_x, step_y;
    ang_t                fold_z, step_z, rot_angle;

    assign x_ext = {{GUARD_W{x_in[DATA_W-1]}}, x_in};
    assign y_ext = {{GUARD_W{y_in[DATA_W-1]}}, y_in};

    cvec_fold #(.W(W)) u_fold (
        .x_i (x_ext),
        .y_i (y_ext),
        .x_o (fold_x),
        .y_o (fold_y),
        .z_o (fold_z)
    );

    cvec_atan_rom u_rom (
        .idx   (st_q.step),
        .angle (rot_angle)
    );

    cvec_step #(.W(W)) u_step (
        .x_i   (st_q.x),
        .y_i   (st_q.y),
        .z_i   (st_q.z),
        .shamt (st_q.step),
        .rot   (rot_angle),
        .x_o   (step_x),
        .y_o   (step_y),
        .z_o   (step_z)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_valid) begin
                st_d.busy = 1'b1;
                st_d.step = '0;
                st_d.x    = fold_x;
                st_d.y    = fold_y;
                st_d.z    = fold_z;
            end
        end else begin
            st_d.x = step_x;
            st_d.y = step_y;
            st_d.z = step_z;
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.mag  = step_x;
                st_d.ang  = step_z;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_ready = !st_q.busy;
    assign done        = st_q.done;
    assign mag_out     = st_q.mag;
    assign angle_out   = st_q.ang;

endmodule

// File: rtl/cvec_polar_chk.sv
module cvec_polar_chk #(
    parameter int W     = 18,
    parameter int ITERS = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_valid,
    input logic         start_ready,
    input logic         done,
    input logic [W-1:0] mag_out
);

    logic [5:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (start_valid && start_ready) begin
            since_q <= 6'd1;
        end else if (since_q != '1) begin
            since_q <= since_q + 6'd1;
        end
    end

    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready) |=> !start_ready);

    assert_done_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> start_ready);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_q == 6'(ITERS + 1)));

    assert_mag_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mag_out[W-1]);

endmodule

bind cvec_polar cvec_polar_chk #(
    .W     (DATA_W + GUARD_W),
    .ITERS (ITERS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .done        (done),
    .mag_out     (mag_out)
);

// File: tb/cvec_polar_bench.sv
module cvec_polar_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic        start_ready;
    logic        done;
    logic [17:0] mag_out;
    logic [15:0] angle_out;

    cvec_polar u_cvec_polar (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_ready (start_ready),
        .x_in        (x_in),
        .y_in        (y_in),
        .done        (done),
        .mag_out     (mag_out),
        .angle_out   (angle_out)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int x;
        int y;
        int acc;
        bit b2b;
    } job_t;

    job_t        sb[$];
    int          checks = 0;
    int          fails = 0;
    int          sent = 0;
    int          ndone = 0;
    int          last_done = -1000;
    logic [17:0] last_mag = '0;
    logic [15:0] last_ang = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic send(input int x, input int y, input bit b2b);
        job_t j;
        @(negedge clk);
        while (!start_ready) @(negedge clk);
        start_valid = 1'b1;
        x_in = 16'(x);
        y_in = 16'(y);
        j.x = x; j.y = y; j.acc = cyc + 1; j.b2b = b2b;
        sb.push_back(j);
        sent++;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected done", 1, 0);
                end else begin
                    job_t j;
                    string rq;
                    j = sb.pop_front();
                    check(cyc - j.acc == 14, "R3", "latency", cyc - j.acc, 14);
                    if (j.b2b)
                        check(cyc - last_done == 15, "R8", "done spacing",
                              cyc - last_done, 15);
                    if (j.x == 0 && j.y == 0) begin
                        check(mag_out == 18'd0, "R7", "zero magnitude",
                              longint'(mag_out), 0);
                    end else begin
                        real ae, me;
                        int  er, d, ma, mr;
                        rq = (j.x == -32768 || j.y == -32768) ? "R6" : "R4";
                        ae = $atan2(real'(j.y), real'(j.x)) * 32768.0 / 3.14159265358979;
                        er = $rtoi(ae + ((ae >= 0.0) ? 0.5 : -0.5));
                        d  = int'($signed(angle_out)) - er;
                        while (d > 32767)  d -= 65536;
                        while (d < -32768) d += 65536;
                        check(d <= 16 && d >= -16, rq, "angle",
                              longint'($signed(angle_out)), er);
                        me = 1.6467602 * $sqrt(real'(j.x) * real'(j.x) + real'(j.y) * real'(j.y));
                        mr = $rtoi(me + 0.5);
                        ma = int'(mag_out);
                        rq = (j.x == -32768 || j.y == -32768) ? "R6" : "R5";
                        check((ma - mr) <= 40 && (mr - ma) <= 40, rq, "magnitude", ma, mr);
                    end
                end
                last_done = cyc;
                last_mag  = mag_out;
                last_ang  = angle_out;
                ndone++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(start_ready == 1'b1, "R1", "ready in reset", start_ready, 1);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mag_out == 18'd0 && angle_out == 16'd0, "R1", "outputs after reset",
              longint'(mag_out) + longint'(angle_out), 0);
        check(start_ready == 1'b1 && done == 1'b0, "R1", "idle after reset",
              start_ready, 1);

        // R4/R5: one vector per quadrant and on each axis
        send(20000, 10000, 1'b0);
        send(-20000, 10000, 1'b1);
        send(-20000, -10000, 1'b1);
        send(20000, -10000, 1'b1);
        send(0, 30000, 1'b1);
        send(0, -30000, 1'b1);
        send(-30000, 0, 1'b1);
        send(30000, 0, 1'b1);
        send(5000, -25000, 1'b1);
        send(-1234, 23456, 1'b1);
        send(32767, 32767, 1'b1);
        // R6: negative full scale
        send(-32768, -32768, 1'b1);
        send(-32768, 0, 1'b1);
        send(0, -32768, 1'b1);
        // R7: zero vector
        send(0, 0, 1'b1);

        // R2: offers while busy are ignored
        send(12000, -7000, 1'b1);
        for (int k = 0; k < 4; k++) begin
            start_valid = 1'b1;
            x_in = 16'(-3000 - k);
            y_in = 16'(900 + k);
            @(negedge clk);
            check(start_ready == 1'b0, "R2", "ready low while busy", start_ready, 0);
        end
        start_valid = 1'b0;

        while (sb.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        // R9: results hold while idle
        check(mag_out == last_mag, "R9", "magnitude held",
              longint'(mag_out), longint'(last_mag));
        check(angle_out == last_ang, "R9", "angle held",
              longint'(angle_out), longint'(last_ang));
        check(done == 1'b0, "R3", "no extra pulse", done, 0);
        check(ndone == sent, "R2", "result count", ndone, sent);
        report();
    end

endmodule